// File: doc/BRIEF.md
# Differential trace timestamp generator

This block measures the time that passes between consecutive timestamp events of a trace stream and hands each measurement to a downstream packet builder. A prescaled counter advances while the block is enabled. When a trigger arrives, the block presents the count on a valid/ready output and restarts both the prescaler and the counter from zero. Each value it reports is therefore the interval since the previous one. There are three triggers: a packet write while the count is nonzero, a wrap of the counter, and a long stretch of cycles with no packet writes.

A mode input selects how the counter is clocked. In the normal mode it counts continuously, and the long-gap trigger is armed. In the line-clocked mode the counter is forced to zero while the trace line reports idle, and the long-gap trigger is disarmed, so only activity produces events. With the enable low the block is inert.

The control is a three-state machine. `ST_OFF` means disabled, with everything cleared. `ST_RUN` means counting and waiting for a trigger. `ST_WAIT` means an event is presented and not yet accepted. The transitions are:

- `ST_OFF`→`ST_RUN` when the enable rises.
- `ST_RUN`→`ST_WAIT` on a trigger.
- `ST_WAIT`→`ST_RUN` on acceptance when no further trigger is pending.
- `ST_WAIT`→`ST_WAIT` on acceptance when a trigger is pending, which reloads the output.
- Any state→`ST_OFF` when the enable falls.

The elapsed time is `ts_value + ts_ovf * 2^CNT_W` prescaled units.

Top module: `trace_delta_timestamp`

## Requirements
- R1: While reset is asserted and after its release, `ts_valid` is 0 until the first event, and `ts_value` and `ts_ovf` read 0.
- R2: `prescale_sel` sets the unit of the count: 00 counts every cycle, 01 every 4th cycle, 10 every 16th and 11 every 64th. N cycles of counting yield floor(N / ratio).
- R3: A `pkt_wr` cycle in which the count, including that cycle's increment, is nonzero produces an event. The event carries the number of units since the enable edge or since the previous capture, and the count restarts from zero.
- R4: A `pkt_wr` cycle in which the count is still zero produces no event.
- R5: When the counter passes its all-ones value, an event is produced with `ts_value` = 0 and `ts_ovf` = 1.
- R6: In normal mode (`async_mode` = 0), IDLE_LIMIT consecutive enabled cycles without `pkt_wr` produce an event carrying the current count.
- R7: With `async_mode` = 1, while `line_idle` is 1 the count is held at zero, and neither packets nor elapsed cycles produce events. Counting resumes on the first cycle with `line_idle` = 0.
- R8: With `ts_en` = 0, no events are produced, and `ts_valid` drops on the cycle after `ts_en` falls.
- R9: While `ts_valid` = 1 and `ts_ready` = 0, `ts_valid`, `ts_value` and `ts_ovf` hold and counting continues. A trigger seen during the hold is emitted on the acceptance edge, with the count measured since the held capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ts_en | input | 1 | Timestamp enable |
| prescale_sel | input | 2 | Count unit: 00=1, 01=4, 10=16, 11=64 cycles |
| async_mode | input | 1 | 1: count only while the trace line is active |
| pkt_wr | input | 1 | A packet was written this cycle |
| line_idle | input | 1 | Trace output line is idle |
| ts_ready | input | 1 | Downstream accepts the presented event |
| ts_valid | output | 1 | Event presented |
| ts_value | output | CNT_W | Units elapsed since previous capture |
| ts_ovf | output | 1 | Counter wrapped within this interval |

## Verification
The properties assume that the control inputs change only between clock edges. They also assume that a withdrawal of `ts_ready` is judged only while `ts_en` stays high, since dropping the enable legitimately discards a held event. The bench drives every input on the falling edge. It changes `prescale_sel` and `async_mode` only while the enable is low, so each interval is measured in a single unit. The hold scenario keeps `ts_en` high for the whole backpressure window.

// File: rtl/ts_pkg.sv
package ts_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_WAIT = 2'd2
    } ts_state_e;

    localparam int PRE_W = 6;

    // last prescaler phase for each select code (ratio minus one)
    function automatic logic [PRE_W-1:0] prescale_last(input logic [1:0] sel);
        logic [PRE_W-1:0] r;
        unique case (sel)
            2'b00:   r = 6'd0;
            2'b01:   r = 6'd3;
            2'b10:   r = 6'd15;
            default: r = 6'd63;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ts_prescaler.sv
module ts_prescaler
    import ts_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       tick
);

    logic [PRE_W-1:0] phase;
    logic [PRE_W-1:0] last;

    assign last = prescale_last(sel);
    assign tick = run && (phase >= last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (clear) begin
            phase <= '0;
        end else if (run) begin
            phase <= tick ? '0 : phase + 1'b1;
        end
    end

endmodule

// File: rtl/ts_delta_counter.sv
module ts_delta_counter #(
    parameter int CNT_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    output logic [CNT_W-1:0] acc_next,
    output logic             wrap,
    output logic             wrapped_seen
);

    logic [CNT_W-1:0] acc;

    assign acc_next = acc + {{(CNT_W-1){1'b0}}, tick};
    assign wrap     = tick && (&acc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc          <= '0;
            wrapped_seen <= 1'b0;
        end else if (clear) begin
            acc          <= '0;
            wrapped_seen <= 1'b0;
        end else begin
            acc          <= acc_next;
            wrapped_seen <= wrapped_seen | wrap;
        end
    end

endmodule

// File: rtl/ts_idle_timer.sv
module ts_idle_timer #(
    parameter int LIMIT = 2000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic activity,
    output logic fire
);

    localparam int IW = $clog2(LIMIT + 1);

    logic [IW-1:0] quiet;

    assign fire = enable && !activity && (quiet == IW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet <= '0;
        end else if (!enable || activity || fire) begin
            quiet <= '0;
        end else begin
            quiet <= quiet + 1'b1;
        end
    end

endmodule

// File: rtl/trace_delta_timestamp.sv
module trace_delta_timestamp
    import ts_pkg::*;
#(
    parameter int CNT_W      = 21,
    parameter int IDLE_LIMIT = 2000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ts_en,
    input  logic [1:0]       prescale_sel,
    input  logic             async_mode,
    input  logic             pkt_wr,
    input  logic             line_idle,
    input  logic             ts_ready,
    output logic             ts_valid,
    output logic [CNT_W-1:0] ts_value,
    output logic             ts_ovf
);

    ts_state_e        state, state_nx;
    logic             active, hold_line, run_cnt, clear_cnt;
    logic             tick, wrap, wrapped_seen, idle_fire;
    logic [CNT_W-1:0] acc_next;
    logic             nonzero, trig, pend, capture;
    logic [CNT_W-1:0] out_value;
    logic             out_ovf;

    assign active    = ts_en && (state != ST_OFF);
    assign hold_line = async_mode && line_idle;
    assign run_cnt   = active && !hold_line;
    assign nonzero   = (acc_next != '0) || wrap || wrapped_seen;
    assign trig      = active && (wrap || idle_fire || (pkt_wr && nonzero && !hold_line));
    assign capture   = ((state == ST_RUN) && trig) ||
                       ((state == ST_WAIT) && ts_en && ts_ready && (pend || trig));
    assign clear_cnt = !active || capture || hold_line;

    ts_prescaler u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear_cnt),
        .run   (run_cnt),
        .sel   (prescale_sel),
        .tick  (tick)
    );

    ts_delta_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (clear_cnt),
        .tick         (tick),
        .acc_next     (acc_next),
        .wrap         (wrap),
        .wrapped_seen (wrapped_seen)
    );

    ts_idle_timer #(.LIMIT(IDLE_LIMIT)) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (active && !async_mode),
        .activity (pkt_wr),
        .fire     (idle_fire)
    );

    // next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:  if (ts_en) state_nx = ST_RUN;
            ST_RUN: begin
                if (!ts_en)    state_nx = ST_OFF;
                else if (trig) state_nx = ST_WAIT;
            end
            ST_WAIT: begin
                if (!ts_en)                          state_nx = ST_OFF;
                else if (ts_ready && !(pend || trig)) state_nx = ST_RUN;
            end
            default: state_nx = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    // output and pending-trigger registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_value <= '0;
            out_ovf   <= 1'b0;
            pend      <= 1'b0;
        end else begin
            if (capture) begin
                out_value <= acc_next;
                out_ovf   <= wrap || wrapped_seen;
            end
            if (!active || capture)              pend <= 1'b0;
            else if ((state == ST_WAIT) && trig) pend <= 1'b1;
        end
    end

    assign ts_valid = (state == ST_WAIT);
    assign ts_value = out_value;
    assign ts_ovf   = out_ovf;

endmodule

// File: rtl/trace_delta_timestamp_chk.sv
module trace_delta_timestamp_chk #(
    parameter int CNT_W = 21
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ts_en,
    input logic             async_mode,
    input logic             line_idle,
    input logic             ts_ready,
    input logic             ts_valid,
    input logic [CNT_W-1:0] ts_value,
    input logic             ts_ovf
);

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !ts_valid);

    // R8
    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ts_en |=> !ts_valid);

    // R9
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_valid && !ts_ready && ts_en) |=> (ts_valid && $stable(ts_value) && $stable(ts_ovf)));

    // R7
    a_r7_line_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_en && async_mode && line_idle && !ts_valid) |=> !ts_valid);

endmodule

bind trace_delta_timestamp trace_delta_timestamp_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ts_en      (ts_en),
    .async_mode (async_mode),
    .line_idle  (line_idle),
    .ts_ready   (ts_ready),
    .ts_valid   (ts_valid),
    .ts_value   (ts_value),
    .ts_ovf     (ts_ovf)
);

// File: tb/trace_delta_timestamp_bench.sv
`timescale 1ns/1ps
module trace_delta_timestamp_bench;

    localparam int CW   = 8;
    localparam int IDLE = 300;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ts_en = 1'b0;
    logic [1:0]    prescale_sel = 2'b00;
    logic          async_mode = 1'b0;
    logic          pkt_wr = 1'b0;
    logic          line_idle = 1'b0;
    logic          ts_ready = 1'b1;
    logic          ts_valid;
    logic [CW-1:0] ts_value;
    logic          ts_ovf;

    int vectors = 0;
    int errors  = 0;

    always #4 clk = ~clk;

    trace_delta_timestamp #(.CNT_W(CW), .IDLE_LIMIT(IDLE)) u_trace_delta_timestamp (
        .clk(clk), .rst_n(rst_n), .ts_en(ts_en), .prescale_sel(prescale_sel),
        .async_mode(async_mode), .pkt_wr(pkt_wr), .line_idle(line_idle),
        .ts_ready(ts_ready), .ts_valid(ts_valid), .ts_value(ts_value), .ts_ovf(ts_ovf)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_pkt();
        pkt_wr = 1'b1;
        @(negedge clk);
        pkt_wr = 1'b0;
    endtask

    task automatic setup(input logic [1:0] sel, input logic amode, input logic lidle);
        ts_en = 1'b0;
        repeat (3) @(negedge clk);
        prescale_sel = sel;
        async_mode   = amode;
        line_idle    = lidle;
        ts_ready     = 1'b1;
        ts_en        = 1'b1;
    endtask

    task automatic t_reset();
        check("R1 valid", 32'(ts_valid), 0);
        check("R1 value", 32'(ts_value), 0);
    endtask

    task automatic t_packets();
        setup(2'b00, 1'b0, 1'b0);
        repeat (25) @(negedge clk);
        pulse_pkt();
        check("R3 first interval", 32'(ts_value), 25);
        check("R3 valid", 32'(ts_valid), 1);
        repeat (6) @(negedge clk);
        pulse_pkt();
        check("R3 second interval", 32'(ts_value), 7);
    endtask

    task automatic t_prescale(input logic [1:0] sel, input int n, input int ratio);
        setup(sel, 1'b0, 1'b0);
        repeat (n) @(negedge clk);
        pulse_pkt();
        check("R2 prescaled value", 32'(ts_value), 32'(n / ratio));
    endtask

    task automatic t_zero_count();
        setup(2'b11, 1'b0, 1'b0);
        repeat (10) @(negedge clk);
        pulse_pkt();
        check("R4 no event on zero count", 32'(ts_valid), 0);
    endtask

    task automatic t_overflow();
        setup(2'b00, 1'b0, 1'b0);
        repeat (256) @(negedge clk);
        check("R5 before wrap", 32'(ts_valid), 0);
        @(negedge clk);
        check("R5 wrap valid", 32'(ts_valid), 1);
        check("R5 wrap value", 32'(ts_value), 0);
        check("R5 wrap flag", 32'(ts_ovf), 1);
    endtask

    task automatic t_idle();
        setup(2'b11, 1'b0, 1'b0);
        repeat (300) @(negedge clk);
        check("R6 before limit", 32'(ts_valid), 0);
        @(negedge clk);
        check("R6 idle event", 32'(ts_valid), 1);
        check("R6 idle value", 32'(ts_value), 4);
        check("R6 idle flag", 32'(ts_ovf), 0);
    endtask

    task automatic t_async();
        int seen = 0;
        setup(2'b00, 1'b1, 1'b1);
        for (int i = 0; i < 350; i++) begin
            pkt_wr = (i == 20) || (i == 200);
            @(negedge clk);
            if (ts_valid) seen++;
        end
        pkt_wr = 1'b0;
        check("R7 no events while line idle", 32'(seen), 0);
        line_idle = 1'b0;
        repeat (12) @(negedge clk);
        pulse_pkt();
        check("R7 count after line active", 32'(ts_value), 13);
        line_idle = 1'b1;
    endtask

    task automatic t_disabled();
        int seen = 0;
        ts_en = 1'b0;
        async_mode = 1'b0;
        for (int i = 0; i < 400; i++) begin
            pkt_wr = (i % 50) == 7;
            @(negedge clk);
            if (ts_valid) seen++;
        end
        pkt_wr = 1'b0;
        check("R8 no events when disabled", 32'(seen), 0);
        setup(2'b00, 1'b0, 1'b0);
        ts_ready = 1'b0;
        repeat (9) @(negedge clk);
        pulse_pkt();
        check("R8 event held", 32'(ts_valid), 1);
        ts_en = 1'b0;
        @(negedge clk);
        check("R8 valid drops after disable", 32'(ts_valid), 0);
        ts_ready = 1'b1;
    endtask

    task automatic t_backpressure();
        setup(2'b00, 1'b0, 1'b0);
        ts_ready = 1'b0;
        repeat (10) @(negedge clk);
        pulse_pkt();
        check("R9 first capture", 32'(ts_value), 10);
        repeat (5) @(negedge clk);
        pulse_pkt();
        repeat (4) @(negedge clk);
        check("R9 held valid", 32'(ts_valid), 1);
        check("R9 held value", 32'(ts_value), 10);
        ts_ready = 1'b1;
        @(negedge clk);
        check("R9 pending emitted", 32'(ts_valid), 1);
        check("R9 pending value", 32'(ts_value), 11);
        @(negedge clk);
        check("R9 released", 32'(ts_valid), 0);
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_packets();
        t_prescale(2'b01, 41, 4);
        t_prescale(2'b10, 70, 16);
        t_zero_count();
        t_overflow();
        t_idle();
        t_async();
        t_disabled();
        t_backpressure();
        ts_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                errors++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule